// File: doc/BRIEF.md
# Checksummed Reply Frame Builder

This block assembles the reply that a bus target sends back to a host once a command has completed. A one-cycle start request captures a result code, a payload length and a format selector. The block then emits a frame one byte at a time towards the target's transmitter over a valid/ready handshake: a header, the payload bytes taken from a byte-wide valid/ready source, and a trailing 8-bit additive checksum.

Two frame formats exist. The standard format carries the result byte and then a length byte ahead of the payload. The legacy format drops the length byte, and its checksum covers only the bytes that are actually sent. While no frame is being built, the transmitter side always sees a fixed filler byte. A host read that arrives with no reply pending therefore still gets a defined answer.

Top module: `rframe_builder`

## Requirements
- R1: After reset the block is idle: `txValid` is 1, `txData` is 0xEC, `srcReady` is 0 and `frameDone` is 0.
- R2: While idle, every byte the transmitter accepts is the filler value 0xEC. Accepting filler bytes does not change the state of the block.
- R3: The first byte of every frame is the `resultCode` captured at the start request.
- R4: With `legacyMode` = 0 the second byte is the payload length. The payload bytes follow in source order, and each source byte is forwarded only in a cycle in which the transmitter takes it.
- R5: The last byte of a standard frame is (result + length + sum of payload bytes) mod 256.
- R6: With `legacyMode` = 1 the frame is result, payload, checksum. The checksum is (result + sum of payload bytes) mod 256.
- R7: A payload length of 0 yields result, [length,] checksum, and no source byte is consumed.
- R8: A requested length above `MAX_LEN` (32) is reduced to `MAX_LEN`. The length byte then reads 32, and exactly 32 source bytes are consumed.
- R9: While the transmitter withholds ready during a frame, `txValid` stays high and `txData` holds its value, and `srcReady` is 0.
- R10: `frameDone` is high for exactly one cycle, the cycle after the checksum byte is accepted. In that cycle the block is already idle.
- R11: A start request that arrives while a frame is in progress is ignored. The frame in flight continues unchanged.
- R12: The checksum restarts from zero for every frame, so back-to-back frames each carry only their own sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to build a frame; honoured only when idle |
| resultCode | input | 8 | Result byte, captured on start |
| payloadLen | input | 8 | Payload byte count, captured on start (clamped to MAX_LEN) |
| legacyMode | input | 1 | 1 = frame without length byte |
| srcValid | input | 1 | Payload source has a byte |
| srcData | input | 8 | Payload byte |
| srcReady | output | 1 | Payload byte taken this cycle |
| txValid | output | 1 | Frame or filler byte available |
| txData | output | 8 | Byte to the transmitter |
| txReady | input | 1 | Transmitter takes the byte |
| frameDone | output | 1 | One-cycle pulse after the checksum byte is taken |

## Verification
The hardest situation to reach is a stall in which source gaps and transmitter back-pressure overlap inside one payload, while a stray start request lands in the same frame. The bench drives both handshakes from independent pseudo-random sequences during long frames, including the clamped 32-byte one. It also injects a start pulse a few cycles into a throttled frame. A scoreboard holds every expected byte and checks that the sequence and the checksums are unaffected.

// File: rtl/rframe_pkg.sv
package rframe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESULT,
    ST_LENGTH,
    ST_PAYLOAD,
    ST_CSUM
  } frameState_e;

  typedef enum logic [2:0] {
    SEL_FILL,
    SEL_RESULT,
    SEL_LENGTH,
    SEL_PAYLOAD,
    SEL_CSUM
  } byteSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     capture;     // latch header fields, clear the sum
    logic     accumulate;  // add the byte just accepted to the sum
    byteSel_e sel;         // which byte drives txData
  } frameStrobe_t;

  localparam logic [7:0] FILL_BYTE = 8'hEC;

endpackage

// File: rtl/rframe_ctrl.sv
module rframe_ctrl
  import rframe_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             srcValid,
  input  logic             txReady,
  input  logic [LEN_W-1:0] lenQ,
  input  logic             legacyQ,
  output frameStrobe_t     strobe,
  output logic             txValid,
  output logic             srcReady,
  output logic             frameDone,
  output logic             frameActive
);

  frameState_e      stateQ, stateD;
  logic [LEN_W-1:0] cntQ, cntD;
  logic             doneQ;
  logic             fire;
  logic             lastPay;

  assign txValid     = (stateQ != ST_PAYLOAD) || srcValid;
  assign srcReady    = (stateQ == ST_PAYLOAD) && txReady;
  assign fire        = txValid && txReady;
  assign lastPay     = (cntQ == lenQ - LEN_W'(1));
  assign frameActive = (stateQ != ST_IDLE);
  assign frameDone   = doneQ;

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    strobe = '{capture: 1'b0, accumulate: 1'b0, sel: SEL_FILL};
    case (stateQ)
      ST_IDLE: begin
        if (startReq) begin
          strobe.capture = 1'b1;
          cntD           = '0;
          stateD         = ST_RESULT;
        end
      end
      ST_RESULT: begin
        strobe.sel = SEL_RESULT;
        if (fire) begin
          strobe.accumulate = 1'b1;
          if (!legacyQ)          stateD = ST_LENGTH;
          else if (lenQ == '0)   stateD = ST_CSUM;
          else                   stateD = ST_PAYLOAD;
        end
      end
      ST_LENGTH: begin
        strobe.sel = SEL_LENGTH;
        if (fire) begin
          strobe.accumulate = 1'b1;
          stateD = (lenQ == '0) ? ST_CSUM : ST_PAYLOAD;
        end
      end
      ST_PAYLOAD: begin
        strobe.sel = SEL_PAYLOAD;
        if (fire) begin
          strobe.accumulate = 1'b1;
          cntD = cntQ + LEN_W'(1);
          if (lastPay) stateD = ST_CSUM;
        end
      end
      ST_CSUM: begin
        strobe.sel = SEL_CSUM;
        if (fire) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
      doneQ  <= (stateQ == ST_CSUM) && fire;
    end
  end

endmodule

// File: rtl/rframe_datapath.sv
module rframe_datapath
  import rframe_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int LEN_W   = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  frameStrobe_t     strobe,
  input  logic [7:0]       resultCode,
  input  logic [7:0]       payloadLen,
  input  logic             legacyMode,
  input  logic [7:0]       srcData,
  output logic [7:0]       txData,
  output logic [LEN_W-1:0] lenQ,
  output logic             legacyQ
);

  localparam logic [7:0] MAX_LEN_BYTE = 8'(MAX_LEN);

  logic [7:0]       resultQ;
  logic [7:0]       sumQ;
  logic [LEN_W-1:0] lenClamp;

  assign lenClamp = (payloadLen > MAX_LEN_BYTE) ? LEN_W'(MAX_LEN)
                                                : payloadLen[LEN_W-1:0];

  always_comb begin
    case (strobe.sel)
      SEL_RESULT:  txData = resultQ;
      SEL_LENGTH:  txData = 8'(lenQ);
      SEL_PAYLOAD: txData = srcData;
      SEL_CSUM:    txData = sumQ;
      default:     txData = FILL_BYTE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      lenQ    <= '0;
      legacyQ <= 1'b0;
      sumQ    <= '0;
    end else if (strobe.capture) begin
      resultQ <= resultCode;
      lenQ    <= lenClamp;
      legacyQ <= legacyMode;
      sumQ    <= '0;
    end else if (strobe.accumulate) begin
      sumQ    <= sumQ + txData;
    end
  end

endmodule

// File: rtl/rframe_builder.sv
module rframe_builder
  import rframe_pkg::*;
#(
  parameter int MAX_LEN = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic [7:0] resultCode,
  input  logic [7:0] payloadLen,
  input  logic       legacyMode,
  input  logic       srcValid,
  input  logic [7:0] srcData,
  output logic       srcReady,
  output logic       txValid,
  output logic [7:0] txData,
  input  logic       txReady,
  output logic       frameDone
);

  localparam int LEN_W = $clog2(MAX_LEN + 1);

  frameStrobe_t     strobe;
  logic [LEN_W-1:0] lenQ;
  logic             legacyQ;
  logic             frameActive;

  rframe_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .srcValid   (srcValid),
    .txReady    (txReady),
    .lenQ       (lenQ),
    .legacyQ    (legacyQ),
    .strobe     (strobe),
    .txValid    (txValid),
    .srcReady   (srcReady),
    .frameDone  (frameDone),
    .frameActive(frameActive)
  );

  rframe_datapath #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .resultCode(resultCode),
    .payloadLen(payloadLen),
    .legacyMode(legacyMode),
    .srcData   (srcData),
    .txData    (txData),
    .lenQ      (lenQ),
    .legacyQ   (legacyQ)
  );

endmodule

// File: rtl/rframe_builder_chk.sv
module rframe_builder_chk (
  input logic       clk,
  input logic       rstN,
  input logic       txValid,
  input logic       txReady,
  input logic [7:0] txData,
  input logic       srcValid,
  input logic       srcReady,
  input logic [7:0] srcData,
  input logic       frameDone,
  input logic       frameActive
);

  // R9
  hold_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameActive && txValid && !txReady |=> txValid && $stable(txData));

  // R9
  src_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    srcReady |-> txReady);

  // R4
  pass_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    srcValid && srcReady |-> txValid && txData == srcData);

  // R2
  filler_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameActive |-> txValid && txData == 8'hEC);

  // R10
  done_after_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !frameActive && $past(txValid && txReady && frameActive));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

endmodule

bind rframe_builder rframe_builder_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .txValid    (txValid),
  .txReady    (txReady),
  .txData     (txData),
  .srcValid   (srcValid),
  .srcReady   (srcReady),
  .srcData    (srcData),
  .frameDone  (frameDone),
  .frameActive(frameActive)
);

// File: tb/test_rframe_builder.sv
`timescale 1ns/100ps
module test_rframe_builder;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic [7:0] resultCode = '0;
  logic [7:0] payloadLen = '0;
  logic       legacyMode = 1'b0;
  logic       srcValid = 1'b0;
  logic [7:0] srcData = '0;
  logic       srcReady;
  logic       txValid;
  logic [7:0] txData;
  logic       txReady = 1'b0;
  logic       frameDone;

  always #2.5 clk = ~clk;

  rframe_builder i_rframe_builder (
    .clk(clk), .rstN(rstN), .startReq(startReq), .resultCode(resultCode),
    .payloadLen(payloadLen), .legacyMode(legacyMode), .srcValid(srcValid),
    .srcData(srcData), .srcReady(srcReady), .txValid(txValid),
    .txData(txData), .txReady(txReady), .frameDone(frameDone)
  );

  int unsigned checks = 0;
  int unsigned fails  = 0;
  int unsigned cycles = 0;
  bit          finished = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  bit         lastQ[$];
  logic [7:0] srcQ[$];

  bit         readyEn  = 1'b0;
  bit         throttle = 1'b0;
  bit         inFrame  = 1'b0;
  bit         srcFire  = 1'b0;
  bit         pendDone = 1'b0;
  bit         holdPrev = 1'b0;
  logic [7:0] holdData = '0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // handshake generator for transmitter ready and payload source
  always begin
    @(posedge clk);
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    txReady = readyEn && (!throttle || lfsr[1]);
    if (srcFire) begin
      void'(srcQ.pop_front());
      srcValid = 1'b0;
    end
    if (!srcValid && srcQ.size() > 0 && (!throttle || lfsr[4])) begin
      srcValid = 1'b1;
      srcData  = srcQ[0];
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (pendDone) begin
        check(frameDone === 1'b1, "R10 done pulse", frameDone, 1);
        pendDone = 1'b0;
      end else if (frameDone) begin
        check(1'b0, "R10 stray done", frameDone, 0);
      end
      if (holdPrev)
        check(txValid === 1'b1 && txData === holdData, "R9 hold", txData, holdData);
      holdPrev = inFrame && txValid && !txReady;
      holdData = txData;
      if (srcReady && !txReady) check(1'b0, "R9 srcReady", srcReady, 0);
      if (txValid && txReady) begin
        if (expQ.size() == 0) begin
          check(txData === 8'hEC, "R2 filler", txData, 8'hEC);
        end else begin
          logic [7:0] e;
          string t;
          bit l;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          l = lastQ.pop_front();
          check(txData === e, t, txData, e);
          if (l) begin
            pendDone = 1'b1;
            inFrame  = 1'b0;
          end
        end
      end
      srcFire = srcValid && srcReady;
    end
  end

  task automatic push(input logic [7:0] b, input string t, input bit l);
    expQ.push_back(b);
    tagQ.push_back(t);
    lastQ.push_back(l);
  endtask

  task automatic sendFrame(input logic [7:0] res, input int len, input bit leg,
                           input bit thr, input bit junk, input string sumTag);
    int effLen;
    logic [7:0] sum;
    effLen = (len > 32) ? 32 : len;
    sum = res;
    push(res, "R3 result", 1'b0);
    if (!leg) begin
      push(8'(effLen), (len > 32) ? "R8 length" : "R4 length", 1'b0);
      sum = sum + 8'(effLen);
    end
    for (int i = 0; i < effLen; i++) begin
      logic [7:0] b;
      b = res ^ 8'(i * 37 + 5);
      srcQ.push_back(b);
      push(b, (len > 32) ? "R8 payload" : "R4 payload", 1'b0);
      sum = sum + b;
    end
    push(sum, sumTag, 1'b1);
    // quiet the transmitter so the start edge takes no filler byte
    readyEn = 1'b0;
    @(posedge clk); #2;
    throttle   = thr;
    startReq   = 1'b1;
    resultCode = res;
    payloadLen = 8'(len);
    legacyMode = leg;
    @(posedge clk); #2;
    startReq = 1'b0;
    inFrame  = 1'b1;
    readyEn  = 1'b1;
    if (junk) begin
      // R11: stray start in the middle of a frame
      repeat (4) @(posedge clk);
      #2;
      startReq = 1'b1; resultCode = 8'h55; payloadLen = 8'd3; legacyMode = ~leg;
      @(posedge clk); #2;
      startReq = 1'b0;
    end
    while (expQ.size() > 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #2;
    readyEn  = 1'b0;
    throttle = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 50000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    // R1
    check(txValid === 1'b1, "R1 txValid", txValid, 1);
    check(txData === 8'hEC, "R1 txData", txData, 8'hEC);
    check(srcReady === 1'b0, "R1 srcReady", srcReady, 0);
    check(frameDone === 1'b0, "R1 frameDone", frameDone, 0);
    // R2: idle reads return filler
    @(posedge clk); #2 readyEn = 1'b1;
    repeat (6) @(posedge clk);
    #2 readyEn = 1'b0;
    repeat (2) @(posedge clk);
    sendFrame(8'h00, 4, 1'b0, 1'b0, 1'b0, "R5 checksum");
    sendFrame(8'h3A, 5, 1'b1, 1'b1, 1'b0, "R6 legacy checksum");
    sendFrame(8'h81, 0, 1'b0, 1'b0, 1'b0, "R7 empty checksum");
    sendFrame(8'h42, 0, 1'b1, 1'b1, 1'b0, "R7 empty legacy checksum");
    sendFrame(8'hC7, 40, 1'b0, 1'b1, 1'b0, "R8 clamped checksum");
    sendFrame(8'hFF, 10, 1'b0, 1'b1, 1'b1, "R11 checksum after stray start");
    // R12: back-to-back frames, sum must restart
    sendFrame(8'h10, 3, 1'b0, 1'b0, 1'b0, "R12 checksum frame a");
    sendFrame(8'h20, 7, 1'b1, 1'b1, 1'b0, "R12 checksum frame b");
    // R2 again after frames: filler with no pending reply
    @(posedge clk); #2 readyEn = 1'b1;
    repeat (4) @(posedge clk);
    #2 readyEn = 1'b0;
    repeat (2) @(posedge clk);
    check(srcQ.size() == 0, "R7 source bytes consumed", srcQ.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule